// File: doc/BRIEF.md
# PWM Output Steering with Dead Band

This block takes one raw pulse-width-modulated signal and routes it onto four bridge channels, A to D. A two-bit mode selects one of four arrangements: one modulated channel; a complementary pair on A/B; or a full bridge in which one channel is held on while a second is modulated. In the full bridge, the direction chooses which two channels are used.

In the complementary-pair mode, each channel's turn-on is held back by a programmable number of instruction-cycle ticks. This dead band keeps both switches of a leg from conducting at the same time. A channel's turn-off is never delayed.

A polarity input selects active-high or active-low drive for all four channels. The mode is sampled only at the period-match strobe, so a period in progress is never cut short or reshaped. The channel levels come from a register, and polarity is applied after it.

Top module: `pwm_steer`

## Requirements
- R1: While reset is asserted, every channel sits at its inactive level: all zeros when `pol_low_i`=0 and all ones when `pol_low_i`=1.
- R2: Mode 2'b00 (single). Channel A follows `pwm_i` one clock later, and channels B, C and D stay inactive. In every mode, the channels reflect the inputs of the previous clock cycle.
- R3: Mode 2'b10 (half bridge). Channel A carries `pwm_i` and channel B carries its complement. A and B are never active in the same cycle.
- R4: Mode 2'b01 (forward). Channel A is continuously active and channel D carries `pwm_i`. B and C are inactive.
- R5: Mode 2'b11 (reverse). Channel C is continuously active and channel B carries `pwm_i`. A and D are inactive.
- R6: In half-bridge mode, each channel becomes active only after its undelayed signal has been high for `dead_i` tick cycles.
  - Counting restarts on every rising edge of that signal.
  - A tick cycle is a cycle in which `tick_i` is high.
  - With `dead_i`=0, no delay is added.
  - A falling edge deactivates the channel in the very next output cycle.
- R7: If `dead_i` is greater than or equal to the number of ticks a pulse lasts, the delayed channel stays inactive for the whole pulse.
- R8: `pol_low_i`=1 inverts all four channels, so the active level is 0. The inversion takes effect in the same cycle.
- R9: A new value on `mode_i` is adopted only in the clock after a cycle in which `period_match_i` is high. Until then, the previous mode continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_i | input | 1 | Raw modulated signal, high = active |
| period_match_i | input | 1 | End-of-period strobe; the mode is loaded after it |
| tick_i | input | 1 | One-cycle instruction tick that paces the dead-band count |
| mode_i | input | 2 | Steering mode: 00 single, 10 half bridge, 01 forward, 11 reverse |
| dead_i | input | DEAD_W (7) | Dead-band length in ticks |
| pol_low_i | input | 1 | 1 = active-low channels |
| ch_o | output | 4 | Channels: bit 0 = A, 1 = B, 2 = C, 3 = D |

## Verification
The assertions take three things for granted:
- `period_match_i` is a single-cycle strobe that arrives at period boundaries.
- `pwm_i` is a clean, per-period waveform.
- `dead_i` may change at any time, because the turn-on check only compares against the live count.

The stimulus generates `pwm_i` from a phase counter with duty values from 1 to the period minus 1. This guarantees that both halves of the complementary pair rise once per period. The strobe is driven only in the last phase of each period. New modes are presented mid-period, so mode adoption is always exercised against the strobe.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_FWD    = 2'b01,
    MODE_HALF   = 2'b10,
    MODE_REV    = 2'b11
  } steer_mode_t;

  localparam int NUM_CH = 4;
  localparam int CH_A   = 0;
  localparam int CH_B   = 1;
  localparam int CH_C   = 2;
  localparam int CH_D   = 3;

endpackage

// File: rtl/steer_mode_reg.sv
module steer_mode_reg
  import pwm_steer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        period_match_i,
  input  logic [1:0]  mode_i,
  output steer_mode_t mode_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)              mode_q <= MODE_SINGLE;
    else if (period_match_i) mode_q <= steer_mode_t'(mode_i);
  end

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_match_i |=> $stable(mode_q));

endmodule

// File: rtl/dead_band_gen.sv
module dead_band_gen #(
  parameter int DEAD_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              raw_i,
  input  logic [DEAD_W-1:0] dead_i,
  output logic              del_o
);

  localparam logic [DEAD_W-1:0] CNT_MAX = {DEAD_W{1'b1}};

  logic              raw_d;
  logic [DEAD_W-1:0] cnt_q;
  logic [DEAD_W-1:0] cnt_eff;
  logic              rise;

  assign rise    = raw_i & ~raw_d;
  assign cnt_eff = rise ? '0 : cnt_q;
  assign del_o   = raw_i && (cnt_eff >= dead_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_d <= 1'b0;
      cnt_q <= '0;
    end else begin
      raw_d <= raw_i;
      if (rise)
        cnt_q <= {{(DEAD_W-1){1'b0}}, tick_i};
      else if (raw_i && tick_i && cnt_q != CNT_MAX)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6
  delayed_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(del_o) && dead_i != '0) |-> $past(raw_i));

endmodule

// File: rtl/pwm_steer.sv
module pwm_steer
  import pwm_steer_pkg::*;
#(
  parameter int DEAD_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_i,
  input  logic              period_match_i,
  input  logic              tick_i,
  input  logic [1:0]        mode_i,
  input  logic [DEAD_W-1:0] dead_i,
  input  logic              pol_low_i,
  output logic [3:0]        ch_o
);

  localparam int PAIR = 2;

  steer_mode_t       mode_q;
  logic [PAIR-1:0]   pair_raw;
  logic [PAIR-1:0]   pair_del;
  logic [NUM_CH-1:0] act_nxt;
  logic [NUM_CH-1:0] act_q;

  steer_mode_reg u_mode (
    .clk            (clk),
    .rst_n          (rst_n),
    .period_match_i (period_match_i),
    .mode_i         (mode_i),
    .mode_q         (mode_q)
  );

  assign pair_raw = {~pwm_i, pwm_i};

  for (genvar g = 0; g < PAIR; g++) begin : g_db
    dead_band_gen #(.DEAD_W(DEAD_W)) u_db (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .raw_i  (pair_raw[g]),
      .dead_i (dead_i),
      .del_o  (pair_del[g])
    );
  end

  always_comb begin
    act_nxt = '0;
    unique case (mode_q)
      MODE_SINGLE: act_nxt[CH_A] = pwm_i;
      MODE_HALF: begin
        act_nxt[CH_A] = pair_del[0];
        act_nxt[CH_B] = pair_del[1];
      end
      MODE_FWD: begin
        act_nxt[CH_A] = 1'b1;
        act_nxt[CH_D] = pwm_i;
      end
      MODE_REV: begin
        act_nxt[CH_C] = 1'b1;
        act_nxt[CH_B] = pwm_i;
      end
      default: act_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_nxt;
  end

  assign ch_o = act_q ^ {NUM_CH{pol_low_i}};

  // R3
  shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_q[CH_A] && act_q[CH_B]));

  // R2
  single_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SINGLE) |=> (act_q[CH_D:CH_B] == '0));

  // R4
  fwd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FWD) |=> (act_q[CH_A] && !act_q[CH_B] && !act_q[CH_C]));

  // R5
  rev_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_REV) |=> (act_q[CH_C] && !act_q[CH_A] && !act_q[CH_D]));

  // R4
  active_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act_q) <= 2);

endmodule

// File: tb/tb_pwm_steer.sv
module tb_pwm_steer;

  localparam int P = 8;

  logic       clk = 1'b0;
  logic       rst_n, pwm, pm, tick, pol;
  logic [1:0] mode;
  logic [6:0] dead;
  logic [3:0] ch;
  logic [1:0] act_mode;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pwm_steer dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .pwm_i          (pwm),
    .period_match_i (pm),
    .tick_i         (tick),
    .mode_i         (mode),
    .dead_i         (dead),
    .pol_low_i      (pol),
    .ch_o           (ch)
  );

  // Active-true expectation for phase k of a period with duty d.
  function automatic logic [3:0] expv(int k, int d, int db, logic [1:0] m, logic tk);
    logic a, ah, bh;
    a  = (k < d);
    ah = a  && (tk ? (k >= db)       : (db == 0));
    bh = !a && (tk ? ((k - d) >= db) : (db == 0));
    case (m)
      2'b00:   return {3'b000, a};
      2'b01:   return {a, 2'b00, 1'b1};
      2'b11:   return {1'b0, 1'b1, a, 1'b0};
      default: return {2'b00, bh, ah};
    endcase
  endfunction

  function automatic string mode_tag(logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R4";
      2'b11:   return "R5";
      default: return "R3";
    endcase
  endfunction

  task automatic check(logic [3:0] exp, string req);
    n_chk++;
    if (ch !== exp) begin
      n_bad++;
      $display("FAIL %s: ch_o=%b expected %b at %0t", req, ch, exp, $time);
    end
  endtask

  task automatic run_period(int d, int db, logic [1:0] m_new, logic p, logic tk,
                            logic do_pm, string req);
    for (int k = 0; k < P; k++) begin
      @(negedge clk);
      pwm  = (k < d);
      tick = tk;
      pol  = p;
      dead = 7'(db);
      if (k == 3) mode = m_new;
      pm = do_pm && (k == P - 1);
      @(posedge clk);
      #1;
      check(expv(k, d, db, act_mode, tk) ^ {4{p}},
            {req, " ", mode_tag(act_mode), (p ? " R8" : "")});
      if (pm) act_mode = mode;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pwm = 1'b0; pm = 1'b0; tick = 1'b1;
    pol = 1'b0; mode = 2'b00; dead = '0;
    act_mode = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    check(4'b0000, "R1");
    pol = 1'b1;
    #1;
    check(4'b1111, "R1 R8");
    @(negedge clk);
    rst_n = 1'b1;
    pol = 1'b0;

    // Sweep of mode, polarity, duty and dead band (R6, R7 in half-bridge)
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 2; p++)
        for (int d = 1; d < P; d++)
          for (int db = 0; db <= P; db++)
            run_period(d, db, 2'(m), p[0], 1'b1, 1'b1, "R6 R7");

    // R9: mode_i changes without a strobe, so the old mode continues
    run_period(3, 0, 2'b11, 1'b0, 1'b1, 1'b1, "R9");
    run_period(3, 0, 2'b01, 1'b0, 1'b1, 1'b0, "R9");
    run_period(5, 0, 2'b00, 1'b0, 1'b1, 1'b0, "R9");
    run_period(5, 0, 2'b10, 1'b0, 1'b1, 1'b1, "R9");

    // R6: no ticks means a nonzero dead band never expires
    run_period(4, 2, 2'b10, 1'b0, 1'b0, 1'b1, "R6");
    run_period(4, 2, 2'b10, 1'b0, 1'b0, 1'b1, "R6");
    run_period(4, 0, 2'b10, 1'b1, 1'b0, 1'b1, "R6");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule